// File: doc/BRIEF.md
# Warp Issue Scheduler

The block picks which resident warp issues next in a multithreaded streaming core. Each warp carries a residency bit, an operand-ready bit supplied by an external scoreboard, and a tag naming its next instruction. Only a resident warp whose operands are ready may compete. The winner is chosen by a rotating priority that starts just past the warp that issued last. Its instruction is then swept across the execution lanes in groups, one group of threads per cycle, until every thread of the warp has been covered.

With the defaults, a warp of 32 threads runs on 8 lanes, so one instruction occupies 4 consecutive cycles. The next winner is picked in the last of those cycles, so a new warp can start on the very next cycle with no idle slot. Once a warp has been picked, it stays out of the competition until the scoreboard drops and then raises its ready bit again. This stops a stale ready level from issuing the same instruction twice. The warp count must be a power of two, and the thread count a multiple of the lane count.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it returns high, `issue_valid` is 0 and `issue_beat` is 0. Asserting reset in the middle of an issue ends that issue on the next edge.
- R2: A warp can be chosen only if its `warp_valid` bit and its `warp_ready` bit are both 1 in the cycle of the choice. A ready warp that is not resident is never issued.
- R3: Each issue lasts exactly THREADS/LANES consecutive cycles, which is 4 with the defaults. During those cycles `issue_beat` counts 0, 1, 2, 3, and `issue_warp` and `issue_tag` stay constant.
- R4: If an eligible warp exists in the last beat of an issue, the next cycle shows `issue_valid`=1 with `issue_beat`=0 for the new warp, with no gap.
- R5: Selection is round-robin. The search starts at the warp index one above the last issued warp and wraps from NUM_WARPS-1 to 0. After reset the search starts at warp 0. A warp that is the only eligible one may be chosen again.
- R6: When no warp is eligible at a choice point, `issue_valid` is 0 and `issue_beat` holds at 0.
- R7: After a warp is chosen, it is not chosen again until its `warp_ready` bit has been 0 in at least one cycle and then returns to 1.
- R8: `issue_tag` equals bits [w*TAG_W +: TAG_W] of `warp_tag`, sampled in the choice cycle for the chosen warp w. Later changes to `warp_tag` do not alter the tag of an issue in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid | input | NUM_WARPS | Resident-warp mask, bit w for warp w |
| warp_ready | input | NUM_WARPS | Operand-ready mask from the scoreboard |
| warp_tag | input | NUM_WARPS*TAG_W | Next-instruction tag per warp, warp w in bits [w*TAG_W +: TAG_W] |
| issue_valid | output | 1 | Issue strobe, high on every beat of an issue |
| issue_warp | output | $clog2(NUM_WARPS) | Index of the warp being issued |
| issue_tag | output | TAG_W | Tag of the instruction being issued |
| issue_beat | output | $clog2(THREADS/LANES) | Lane-group counter; beat b covers threads b*LANES to b*LANES+LANES-1 |

## Verification
The assertions assume that `warp_valid` and `warp_ready` are clean levels that change only between clock edges. They also assume that the scoreboard lowers a warp's ready bit at some point after that warp is chosen. Otherwise the warp stays locked out, which is intended behaviour but leaves nothing to check. The stimulus changes every input on the falling edge only. After each single-issue vector it clears all ready bits, so the lock-out is released before the next vector. It only holds ready high across an issue where the test is meant to show back-to-back switching or a refused re-issue.

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 32,
  parameter int THREADS   = 32,
  parameter int LANES     = 8,
  parameter int TAG_W     = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_WARPS-1:0]                 warp_valid,
  input  logic [NUM_WARPS-1:0]                 warp_ready,
  input  logic [NUM_WARPS*TAG_W-1:0]           warp_tag,
  output logic                                 issue_valid,
  output logic [$clog2(NUM_WARPS)-1:0]         issue_warp,
  output logic [TAG_W-1:0]                     issue_tag,
  output logic [$clog2(THREADS/LANES)-1:0]     issue_beat
);
  localparam int BEATS  = THREADS / LANES;
  localparam int WID_W  = $clog2(NUM_WARPS);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [NUM_WARPS-1:0] consumed;
  logic [NUM_WARPS-1:0] elig;
  logic [WID_W-1:0]     last_warp;
  logic [WID_W-1:0]     pick;
  logic                 found;
  logic                 choose;
  logic                 take;

  assign elig   = warp_valid & warp_ready & ~consumed;
  assign choose = !issue_valid || issue_beat == LAST_BEAT;
  assign take   = choose && found;

  always_comb begin
    logic [WID_W-1:0] idx;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_WARPS; i++) begin
      idx = last_warp + WID_W'(i + 1);
      if (!found && elig[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_valid <= 1'b0;
      issue_beat  <= '0;
      issue_warp  <= '0;
      issue_tag   <= '0;
      last_warp   <= WID_W'(NUM_WARPS - 1);
      consumed    <= '0;
    end else begin
      consumed <= (consumed & warp_ready) |
                  (take ? (NUM_WARPS'(1) << pick) : '0);
      if (take) begin
        issue_valid <= 1'b1;
        issue_beat  <= '0;
        issue_warp  <= pick;
        issue_tag   <= warp_tag[pick*TAG_W +: TAG_W];
        last_warp   <= pick;
      end else if (choose) begin
        issue_valid <= 1'b0;
        issue_beat  <= '0;
      end else begin
        issue_beat <= issue_beat + 1'b1;
      end
    end
  end

  a_r3_beat_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_beat != LAST_BEAT) |=>
      (issue_valid && issue_beat == $past(issue_beat) + 1'b1 &&
       $stable(issue_warp) && $stable(issue_tag)));

  a_r2_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(issue_valid) || (issue_valid && issue_beat == '0)) |->
      |($past(warp_valid & warp_ready) & (NUM_WARPS'(1) << issue_warp)));

  a_r4_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_beat == LAST_BEAT && |elig) |=>
      (issue_valid && issue_beat == '0));

  a_r6_idle_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> issue_beat == '0);

  a_r7_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_beat == LAST_BEAT && $stable(warp_ready) &&
     $past(issue_valid)) |=>
      !(issue_valid && issue_beat == '0 && issue_warp == $past(issue_warp)));
endmodule

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb_top;
  localparam int N = 32;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  warp_valid;
  logic [N-1:0]  warp_ready;
  logic [N*TW-1:0] warp_tag;
  logic          issue_valid;
  logic [4:0]    issue_warp;
  logic [TW-1:0] issue_tag;
  logic [1:0]    issue_beat;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  warp_issue_sched dut_i (
    .clk(clk), .rst_n(rst_n), .warp_valid(warp_valid), .warp_ready(warp_ready),
    .warp_tag(warp_tag), .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_tag(issue_tag), .issue_beat(issue_beat));

  localparam int NV = 8;
  localparam logic [31:0] TV_VALID [NV] = '{
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0001,
    32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_00F0, 32'hFFFF_FFFF};
  localparam logic [31:0] TV_READY [NV] = '{
    32'h0000_0020, 32'h0000_0208, 32'h0000_0208, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0FF0, 32'h8000_0010};
  localparam int TV_WARP [NV] = '{5, 9, 3, 31, 0, 0, 4, 31};

  function automatic logic [TW-1:0] tag_of(int w);
    return TW'(w * 3 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue_once(input logic [31:0] v, input logic [31:0] r, input int w);
    @(negedge clk); warp_valid = v; warp_ready = r;
    @(negedge clk);
    chk(issue_valid == 1'b1, "R2 strobe", int'(issue_valid), 1);
    chk(int'(issue_warp) == w, "R5 warp", int'(issue_warp), w);
    chk(issue_beat == 2'd0, "R3 beat0", int'(issue_beat), 0);
    chk(issue_tag == tag_of(w), "R8 tag", int'(issue_tag), int'(tag_of(w)));
    warp_ready = '0;
    for (int b = 1; b < 4; b++) begin
      @(negedge clk);
      chk(issue_valid && int'(issue_beat) == b && int'(issue_warp) == w,
          "R3 sweep", int'(issue_beat), b);
    end
    @(negedge clk);
    chk(issue_valid == 1'b0, "R6 idle after", int'(issue_valid), 0);
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; warp_valid = '0; warp_ready = '0;
    for (int w = 0; w < N; w++) warp_tag[w*TW +: TW] = tag_of(w);
    repeat (3) @(negedge clk);
    chk(issue_valid == 1'b0 && issue_beat == 2'd0, "R1 reset", int'(issue_valid), 0);
    warp_valid = '1; warp_ready = '1;
    @(negedge clk);
    chk(issue_valid == 1'b0, "R1 held in reset", int'(issue_valid), 0);
    warp_valid = '0; warp_ready = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(issue_valid == 1'b0 && issue_beat == 2'd0, "R1 after release", int'(issue_valid), 0);

    for (int i = 0; i < NV; i++) issue_once(TV_VALID[i], TV_READY[i], TV_WARP[i]);

    // R4 / R7: back-to-back, pointer now at 31
    @(negedge clk); warp_valid = '1; warp_ready = 32'h0000_0044;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(issue_valid && int'(issue_warp) == (k < 4 ? 2 : 6) && int'(issue_beat) == k % 4,
          "R4 no gap", int'(issue_warp), (k < 4 ? 2 : 6));
    end
    @(negedge clk);
    chk(issue_valid == 1'b0, "R7 no reissue with stale ready", int'(issue_valid), 0);
    warp_ready = '0;
    @(negedge clk); warp_ready = 32'h0000_0004;
    @(negedge clk);
    chk(issue_valid && issue_warp == 5'd2 && issue_beat == 2'd0, "R7 rearm", int'(issue_warp), 2);
    warp_tag[2*TW +: TW] = 8'hAA; warp_ready = '0;
    @(negedge clk);
    chk(issue_tag == tag_of(2), "R8 tag held", int'(issue_tag), int'(tag_of(2)));
    repeat (2) @(negedge clk);
    chk(issue_tag == tag_of(2) && issue_beat == 2'd3, "R8 tag last beat", int'(issue_tag), int'(tag_of(2)));
    @(negedge clk);
    warp_tag[2*TW +: TW] = tag_of(2);

    // R6 idle with nothing resident
    warp_valid = '0; warp_ready = '1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!issue_valid && issue_beat == 2'd0, "R6 idle", int'(issue_valid), 0);
    end

    // R2 residency gating
    warp_valid = 32'h0000_0400; warp_ready = ~32'h0000_0400;
    @(negedge clk); @(negedge clk);
    chk(issue_valid == 1'b0, "R2 not ready not issued", int'(issue_valid), 0);
    warp_ready = '0;
    issue_once(32'h0000_0400, 32'h0000_0400, 10);

    // R1 reset mid-issue
    @(negedge clk); warp_valid = '1; warp_ready = 32'h0000_1000;
    @(negedge clk);
    chk(issue_valid && issue_warp == 5'd12, "R5 before reset", int'(issue_warp), 12);
    rst_n = 1'b0; warp_ready = '0;
    @(negedge clk);
    chk(!issue_valid && issue_beat == 2'd0, "R1 mid-issue reset", int'(issue_valid), 0);
    rst_n = 1'b1;
    issue_once(32'hFFFF_FFFF, 32'h0000_0003, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule